// File: doc/BRIEF.md
# Bus Turnaround Idle Cycle Inserter

This block sits between the request sequencer of a bus master and the timing generator for the external bus. It remembers whether the last completed external cycle was a read. When the next request is a write to a slow device that may still be driving the data bus, it holds that write back for a few idle states. During those states no strobe or chip select is active and the data driver stays in high impedance. Once the last idle state has passed, it releases the write with a one-cycle go pulse.

Two conditions must both hold for idle states to be inserted: the write-after-read enable is set, and the write directly follows a completed read. The length of the gap comes from one of two 2-bit count codes, A or B. The target area's bit in an eight-bit select mask picks which code applies. The count and the write flag are captured when a request is accepted, so register changes made while idle states run only affect later accesses.

Top module: `busIdleInserter`

## Requirements
- R1: After reset `idleActive` and `cycleGo` are 0 with no request pending, and the memory of the previous access reads "no prior read", so the first write after reset gets 0 idle states.
- R2: A read request accepted in the ready state raises `cycleGo` in the same cycle, with no idle state.
- R3: With `wrIdleEn` = 1, a write whose previous completed external cycle was a read is held back for a run of idle states before `cycleGo` is raised.
- R4: With `wrIdleEn` = 0, a write that follows a read gets `cycleGo` in the same cycle it is requested, with no idle state.
- R5: Bit `reqArea` of `areaSel` picks the count code for the access: value 0 selects `cntCodeA` and value 1 selects `cntCodeB`.
- R6: The selected code gives the number of idle states: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R7: A write after a write, and a read after a write, get no idle state.
- R8: `idleActive` is high in consecutive cycles only, `cycleGo` is low while it is high, and `cycleGo` is raised in the cycle right after the last idle state.
- R9: Changes to `cntCodeA`, `cntCodeB` or `areaSel` made while idle states are running do not change the length of the current run.
- R10: `cycleGo` is a single-cycle pulse per accepted request. No further pulse occurs until `cycleDone` marks that bus cycle complete, and the type of the previous access is updated only on `cycleDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until `cycleGo` |
| reqArea | input | 3 | Target area 0..7 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| wrIdleEn | input | 1 | Enables idle states for a write after a read |
| areaSel | input | 8 | Per-area code select, 1 = code B |
| cntCodeA | input | 2 | Idle count code A |
| cntCodeB | input | 2 | Idle count code B |
| cycleDone | input | 1 | Pulse: the started bus cycle has completed |
| idleActive | output | 1 | Idle state in progress; all strobes must stay inactive |
| cycleGo | output | 1 | Start the requested bus cycle now |

## Verification
The assertions assume that a requester keeps `reqValid` and its area and direction steady from the moment it raises the request until it sees `cycleGo`. They also assume that `cycleDone` arrives only while a started cycle is outstanding. The directed tasks drive every request this way. Each task holds the request one cycle past the go pulse and only then deasserts it. It then sends exactly one `cycleDone` pulse before issuing the next request, so the previous-access memory is always updated by a legitimate completion.

// File: rtl/busIdlePkg.sv
package busIdlePkg;
  localparam int NUM_AREAS = 8;
  localparam int CODE_W    = 2;
  localparam int AREA_W    = $clog2(NUM_AREAS);
  localparam int CNT_W     = CODE_W + 1;
  localparam int MAX_IDLE  = 1 << CODE_W;

  typedef struct packed {
    logic accept;   // capture request type
    logic loadCnt;  // load idle counter
    logic decCnt;   // step idle counter
    logic commit;   // bus cycle completed
  } idleStrobes_t;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_IDLE  = 2'd1,
    ST_GO    = 2'd2,
    ST_BUSY  = 2'd3
  } idleState_t;
endpackage

// File: rtl/idleDatapath.sv
module idleDatapath
  import busIdlePkg::*;
#(
  parameter int AREAS = NUM_AREAS,
  parameter int CW    = CODE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  idleStrobes_t              strb,
  input  logic [$clog2(AREAS)-1:0]  reqArea,
  input  logic                      reqWrite,
  input  logic                      wrIdleEn,
  input  logic [AREAS-1:0]          areaSel,
  input  logic [CW-1:0]             cntCodeA,
  input  logic [CW-1:0]             cntCodeB,
  output logic                      needIdle,
  output logic                      cntLast
);
  localparam int CNTW = CW + 1;

  logic            lastRead;
  logic            pendWrite;
  logic [CNTW-1:0] idleCnt;
  logic [CW-1:0]   selCode;

  assign selCode  = areaSel[reqArea] ? cntCodeB : cntCodeA;
  assign needIdle = wrIdleEn && reqWrite && lastRead;
  assign cntLast  = (idleCnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRead  <= 1'b0;
      pendWrite <= 1'b0;
      idleCnt   <= '0;
    end else begin
      if (strb.accept)  pendWrite <= reqWrite;
      if (strb.commit)  lastRead  <= !pendWrite;
      if (strb.loadCnt) idleCnt   <= CNTW'(selCode) + CNTW'(1);
      else if (strb.decCnt && idleCnt != '0) idleCnt <= idleCnt - CNTW'(1);
    end
  end

  // R10: previous-access memory moves only on a completed cycle
  a_r10_type_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(lastRead));
  // R6: a freshly loaded counter never exceeds the largest idle run
  a_r6_load_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (idleCnt >= CNTW'(1) && idleCnt <= CNTW'(MAX_IDLE)));
endmodule

// File: rtl/idleControl.sv
module idleControl
  import busIdlePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         cycleDone,
  input  logic         needIdle,
  input  logic         cntLast,
  output idleStrobes_t strb,
  output logic         idleActive,
  output logic         cycleGo
);
  idleState_t state, nextState;
  logic [CNT_W:0] idleRun;

  always_comb begin
    nextState  = state;
    strb       = '0;
    idleActive = 1'b0;
    cycleGo    = 1'b0;
    unique case (state)
      ST_READY: if (reqValid) begin
        strb.accept = 1'b1;
        if (needIdle) begin
          strb.loadCnt = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          cycleGo   = 1'b1;
          nextState = ST_BUSY;
        end
      end
      ST_IDLE: begin
        idleActive  = 1'b1;
        strb.decCnt = 1'b1;
        if (cntLast) nextState = ST_GO;
      end
      ST_GO: begin
        cycleGo   = 1'b1;
        nextState = ST_BUSY;
      end
      ST_BUSY: if (cycleDone) begin
        strb.commit = 1'b1;
        nextState   = ST_READY;
      end
      default: nextState = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_READY;
      idleRun <= '0;
    end else begin
      state   <= nextState;
      idleRun <= idleActive ? idleRun + 1'b1 : '0;
    end
  end

  // R8: go follows directly after the last idle state
  a_r8_go_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idleActive) |-> cycleGo);
  // R8: go never overlaps an idle state
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleGo && idleActive));
  // R3: an idle run starts only for a pending write that needs one
  a_r3_idle_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleActive) |-> $past(reqValid && needIdle));
  // R6: an idle run is never longer than the largest code allows
  a_r6_idle_len_max: assert property (@(posedge clk) disable iff (!rstN)
    idleRun <= (CNT_W+1)'(MAX_IDLE));
  // R10: one go pulse per request
  a_r10_single_go: assert property (@(posedge clk) disable iff (!rstN)
    cycleGo |=> !cycleGo);
endmodule

// File: rtl/busIdleInserter.sv
module busIdleInserter
  import busIdlePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqWrite,
  input  logic                 wrIdleEn,
  input  logic [NUM_AREAS-1:0] areaSel,
  input  logic [CODE_W-1:0]    cntCodeA,
  input  logic [CODE_W-1:0]    cntCodeB,
  input  logic                 cycleDone,
  output logic                 idleActive,
  output logic                 cycleGo
);
  idleStrobes_t strb;
  logic needIdle;
  logic cntLast;

  idleDatapath #(.AREAS(NUM_AREAS), .CW(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqArea(reqArea), .reqWrite(reqWrite), .wrIdleEn(wrIdleEn),
    .areaSel(areaSel), .cntCodeA(cntCodeA), .cntCodeB(cntCodeB),
    .needIdle(needIdle), .cntLast(cntLast)
  );

  idleControl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cycleDone(cycleDone),
    .needIdle(needIdle), .cntLast(cntLast), .strb(strb),
    .idleActive(idleActive), .cycleGo(cycleGo)
  );
endmodule

// File: tb/sim_busIdleInserter.sv
module sim_busIdleInserter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqArea = '0;
  logic       reqWrite = 1'b0;
  logic       wrIdleEn = 1'b0;
  logic [7:0] areaSel = '0;
  logic [1:0] cntCodeA = '0;
  logic [1:0] cntCodeB = '0;
  logic       cycleDone = 1'b0;
  logic       idleActive;
  logic       cycleGo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busIdleInserter u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqArea(reqArea),
    .reqWrite(reqWrite), .wrIdleEn(wrIdleEn), .areaSel(areaSel),
    .cntCodeA(cntCodeA), .cntCodeB(cntCodeB), .cycleDone(cycleDone),
    .idleActive(idleActive), .cycleGo(cycleGo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full access; counts idle states before go, checks go and completion.
  task automatic access(input int area, input bit wr, input int expIdle,
                        input string req, input bit midChange);
    int idles = 0;
    bit got = 1'b0;
    bit gap = 1'b0;
    reqArea  = 3'(area);
    reqWrite = wr;
    reqValid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1;
      if (cycleGo) begin
        got = 1'b1;
        check(!idleActive, "R8 go without idle", int'(idleActive), 0);
        break;
      end
      if (idleActive) begin
        if (gap) check(1'b0, "R8 contiguous idle", 1, 0);
        idles++;
        if (midChange && idles == 1) begin
          cntCodeA = 2'b11;
          cntCodeB = 2'b11;
          areaSel  = ~areaSel;
        end
      end else if (idles > 0) gap = 1'b1;
      @(negedge clk);
    end
    check(got, {req, " go seen"}, int'(got), 1);
    check(idles == expIdle, {req, " idle count"}, idles, expIdle);
    @(negedge clk);
    #1;
    check(!cycleGo && !idleActive, "R10 no go while busy", int'(cycleGo), 0);
    reqValid = 1'b0;
    @(negedge clk);
    #1;
    check(!cycleGo, "R10 no go before done", int'(cycleGo), 0);
    cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!idleActive && !cycleGo, "R1 reset outputs", int'(idleActive) + int'(cycleGo), 0);
    @(negedge clk);
  endtask

  task automatic tFirstWrite();
    wrIdleEn = 1'b1;
    access(0, 1'b1, 0, "R1 first write", 1'b0);
  endtask

  task automatic tReadWrite();
    areaSel = 8'b1010_0000; cntCodeA = 2'b00; cntCodeB = 2'b10;
    access(0, 1'b0, 0, "R2 read", 1'b0);
    access(0, 1'b1, 1, "R3 write after read code 00", 1'b0);
  endtask

  task automatic tNoIdleCases();
    access(1, 1'b1, 0, "R7 write after write", 1'b0);
    access(2, 1'b0, 0, "R7 read after write", 1'b0);
  endtask

  task automatic tSelect();
    access(2, 1'b0, 0, "R2 read", 1'b0);
    access(5, 1'b1, 3, "R5 area5 code B 10", 1'b0);
    access(7, 1'b0, 0, "R2 read", 1'b0);
    access(4, 1'b1, 1, "R5 area4 code A 00", 1'b0);
  endtask

  task automatic tCodes();
    cntCodeA = 2'b11;
    access(3, 1'b0, 0, "R2 read", 1'b0);
    access(3, 1'b1, 4, "R6 code 11", 1'b0);
    cntCodeA = 2'b01;
    access(3, 1'b0, 0, "R2 read", 1'b0);
    access(3, 1'b1, 2, "R6 code 01", 1'b0);
  endtask

  task automatic tDisabled();
    wrIdleEn = 1'b0;
    access(6, 1'b0, 0, "R2 read", 1'b0);
    access(6, 1'b1, 0, "R4 disabled", 1'b0);
    wrIdleEn = 1'b1;
  endtask

  task automatic tMidChange();
    areaSel = 8'h00; cntCodeA = 2'b00; cntCodeB = 2'b00;
    access(0, 1'b0, 0, "R2 read", 1'b0);
    access(0, 1'b1, 1, "R9 change during idle", 1'b0);
    access(0, 1'b0, 0, "R2 read", 1'b0);
    cntCodeA = 2'b01; cntCodeB = 2'b01; areaSel = 8'h00;
    access(0, 1'b1, 2, "R9 change during idle", 1'b1);
  endtask

  initial begin
    tReset();
    tFirstWrite();
    tReadWrite();
    tNoIdleCases();
    tSelect();
    tCodes();
    tDisabled();
    tMidChange();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule